// File: doc/BRIEF.md
# Multi-Lane Segmented Serial Adder

This block adds two long binary words that arrive over `LANES` parallel bit-serial lanes. Lane `l` carries the contiguous slice of positions `l*SEG_LEN` up to `l*SEG_LEN+SEG_LEN-1`. All lanes advance together, one operand bit pair per lane per cycle, least significant position of each slice first. The sum leaves in the same lane layout and the same bit order.

Each lane works in three phases. First it classifies every incoming bit pair as kill, propagate or generate. It stores that symbol in a local buffer that can map to block RAM, and it folds the symbol into one summary for the whole slice. Next, one resolve cycle ripples the slice summaries from the lowest lane upward, which gives every lane its incoming carry. Finally each lane reads its buffer back in order, starting from that carry, and emits one sum bit per cycle. A one-cycle done pulse and the carry out of the whole word follow the last sum bit.

Top module: `segadd_top`

## Requirements
- R1: Each bit pair is classified as kill (both bits 0, code 2'b00), propagate (exactly one bit 1, code 2'b01) or generate (both bits 1, code 2'b10). Code 2'b11 is never stored.
- R2: Over one run, sum bit `k` of lane `l` equals bit `l*SEG_LEN+k` of A+B, where A and B are the full words driven across all lanes.
- R3: The bit pair at slice index `k` is sampled on the `k`-th clock edge after the edge that samples `start_i`, counting that edge as 0. Sum bit `k` is presented after edge `SEG_LEN+2+k`. `sum_valid_o` is high for exactly those `SEG_LEN` consecutive cycles.
- R4: The carry into the lowest lane is zero. A lowest slice made only of propagate positions sums to all ones.
- R5: `done_o` is a one-cycle pulse in the cycle directly after the last valid sum bit. It is asserted exactly once per run.
- R6: While `done_o` is high, `carry_out_o` equals bit `LANES*SEG_LEN` of A+B.
- R7: `start_i` and the operand inputs are ignored outside loading. They neither change the result nor begin a further run.
- R8: A lane whose entire slice is propagate passes its incoming carry unchanged to the next lane, including over a chain of several such lanes.
- R9: After reset, `sum_valid_o`, `done_o` and `carry_out_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a run when idle; its cycle also carries slice bit 0 |
| a_i | input | LANES | Operand A bit, one per lane |
| b_i | input | LANES | Operand B bit, one per lane |
| sum_o | output | LANES | Sum bit, one per lane |
| sum_valid_o | output | 1 | `sum_o` holds a valid bit |
| done_o | output | 1 | One-cycle pulse after the final sum bit |
| carry_out_o | output | 1 | Carry out of the whole word, valid with `done_o` |

## Verification
The driver records the cycle in which it raises `start_i` and queues three expectations: the first valid cycle (`SEG_LEN+3` cycles later in the bench's cycle count), the `SEG_LEN` per-lane sum words, and the word carry. The monitor samples on falling edges. It checks the rising edge of `sum_valid_o` against that cycle and then compares each valid beat in order. It checks that `done_o` comes in the first cycle after the valid window, together with the carry. Runs that keep `start_i` high and the operand bits busy through resolve and replay must leave no unexpected valid beat.

// File: rtl/segadd_pkg.sv
package segadd_pkg;

  typedef enum logic [1:0] {
    SYM_KILL = 2'b00,
    SYM_PROP = 2'b01,
    SYM_GEN  = 2'b10
  } sym_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_RESOLVE,
    PH_REPLAY,
    PH_DRAIN
  } phase_t;

  function automatic sym_t classify(input logic a, input logic b);
    if (a && b)      return SYM_GEN;
    else if (a ^ b)  return SYM_PROP;
    else             return SYM_KILL;
  endfunction

  // Combine an older summary with a newer, higher-order symbol.
  function automatic sym_t absorb(input sym_t older, input sym_t newer);
    return (newer == SYM_PROP) ? older : newer;
  endfunction

  function automatic logic carry_through(input sym_t s, input logic cin);
    return (s == SYM_PROP) ? cin : (s == SYM_GEN);
  endfunction

endpackage

// File: rtl/segadd_ctrl.sv
module segadd_ctrl
  import segadd_pkg::*;
#(
  parameter int SEG_LEN = 8,
  localparam int AW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          wr_en,
  output logic          wr_first,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          seed_en,
  output logic          emit_en,
  output logic          done_set,
  output logic          sum_valid_o,
  output logic          done_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(SEG_LEN - 1);

  phase_t        phase;
  logic [AW-1:0] idx;
  logic          at_last;
  logic          rd_vld_q, rd_last_q, out_last_q, sum_valid_q, done_q;

  assign at_last  = (idx == LAST_IDX);
  assign wr_en    = ((phase == PH_IDLE) && start_i) || (phase == PH_LOAD);
  assign wr_first = (phase == PH_IDLE);
  assign wr_addr  = (phase == PH_IDLE) ? '0 : idx;
  assign rd_en    = (phase == PH_REPLAY);
  assign rd_addr  = idx;
  assign seed_en  = (phase == PH_RESOLVE);
  assign done_set = (phase == PH_DRAIN) && out_last_q;
  assign emit_en  = rd_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start_i) begin
          if (SEG_LEN == 1) begin
            phase <= PH_RESOLVE;
          end else begin
            phase <= PH_LOAD;
            idx   <= AW'(1);
          end
        end
        PH_LOAD: begin
          if (at_last) begin
            phase <= PH_RESOLVE;
            idx   <= '0;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        PH_RESOLVE: begin
          phase <= PH_REPLAY;
          idx   <= '0;
        end
        PH_REPLAY: begin
          if (at_last) begin
            phase <= PH_DRAIN;
            idx   <= '0;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        PH_DRAIN: if (out_last_q) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q    <= 1'b0;
      rd_last_q   <= 1'b0;
      out_last_q  <= 1'b0;
      sum_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      rd_vld_q    <= rd_en;
      rd_last_q   <= rd_en && at_last;
      out_last_q  <= rd_vld_q && rd_last_q;
      sum_valid_q <= rd_vld_q;
      done_q      <= done_set;
    end
  end

  assign sum_valid_o = sum_valid_q;
  assign done_o      = done_q;

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: the end of the valid window is marked by done
  a_r5_done_after_window: assert property (@(posedge clk) disable iff (rst)
    $fell(sum_valid_o) |-> done_o);

  // R3: no sum is presented while operands are still being loaded
  a_r3_quiet_in_load: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD) |-> !sum_valid_o);

  // R7: a start seen while busy never (re)enters loading
  a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start_i) |=> (phase != PH_LOAD || $past(phase) == PH_LOAD));

  // R3: the slice index stays inside the buffer
  a_r3_index_bound: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX);

endmodule

// File: rtl/segadd_lane.sv
module segadd_lane
  import segadd_pkg::*;
#(
  parameter int SEG_LEN = 8,
  localparam int AW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_i,
  input  logic          b_i,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          seed_en,
  input  logic          cin_i,
  input  logic          emit_en,
  output logic          sum_o,
  output sym_t          summary_o
);

  sym_t       sym_in;
  logic [1:0] buf_mem [SEG_LEN];
  logic [1:0] rd_q;
  sym_t       rd_sym;
  sym_t       summ_q;
  logic       run_c;
  logic       sum_q;

  assign sym_in = classify(a_i, b_i);
  assign rd_sym = sym_t'(rd_q);

  // Simple dual-port buffer, registered read, no reset: block RAM friendly.
  always_ff @(posedge clk) begin
    if (wr_en) buf_mem[wr_addr] <= sym_in;
    if (rd_en) rd_q <= buf_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)         summ_q <= SYM_PROP;
    else if (wr_en)  summ_q <= wr_first ? sym_in : absorb(summ_q, sym_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_c <= 1'b0;
      sum_q <= 1'b0;
    end else if (seed_en) begin
      run_c <= cin_i;
    end else if (emit_en) begin
      sum_q <= (rd_sym == SYM_PROP) ^ run_c;
      run_c <= carry_through(rd_sym, run_c);
    end
  end

  assign sum_o     = sum_q;
  assign summary_o = summ_q;

  // R1: code 2'b11 is never produced by the classifier
  a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sym_in != 2'b11);

  // R1: replayed symbols are legal codes
  a_r1_replay_legal: assert property (@(posedge clk) disable iff (rst)
    emit_en |-> rd_q != 2'b11);

endmodule

// File: rtl/segadd_carry_chain.sv
module segadd_carry_chain
  import segadd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  sym_t [LANES-1:0] summary_i,
  output logic [LANES-1:0] cin_o,
  output logic             cout_o
);

  logic [LANES:0] c;

  assign c[0] = 1'b0;

  for (genvar l = 0; l < LANES; l++) begin : g_link
    assign c[l+1]   = carry_through(summary_i[l], c[l]);
    assign cin_o[l] = c[l];
  end

  assign cout_o = c[LANES];

endmodule

// File: rtl/segadd_top.sv
module segadd_top
  import segadd_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SEG_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LANES-1:0] a_i,
  input  logic [LANES-1:0] b_i,
  output logic [LANES-1:0] sum_o,
  output logic             sum_valid_o,
  output logic             done_o,
  output logic             carry_out_o
);

  localparam int AW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  logic             wr_en, wr_first, rd_en, seed_en, emit_en, done_set;
  logic [AW-1:0]    wr_addr, rd_addr;
  sym_t [LANES-1:0] summaries;
  logic [LANES-1:0] lane_cin;
  logic             chain_cout;
  logic             cout_hold, cout_q;

  segadd_ctrl #(.SEG_LEN(SEG_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .wr_en(wr_en), .wr_first(wr_first), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .seed_en(seed_en),
    .emit_en(emit_en), .done_set(done_set),
    .sum_valid_o(sum_valid_o), .done_o(done_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    segadd_lane #(.SEG_LEN(SEG_LEN)) u_lane (
      .clk(clk), .rst(rst), .a_i(a_i[l]), .b_i(b_i[l]),
      .wr_en(wr_en), .wr_first(wr_first), .wr_addr(wr_addr),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .seed_en(seed_en), .cin_i(lane_cin[l]), .emit_en(emit_en),
      .sum_o(sum_o[l]), .summary_o(summaries[l])
    );
  end

  segadd_carry_chain #(.LANES(LANES)) u_chain (
    .summary_i(summaries), .cin_o(lane_cin), .cout_o(chain_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cout_hold <= 1'b0;
      cout_q    <= 1'b0;
    end else begin
      if (seed_en)  cout_hold <= chain_cout;
      if (done_set) cout_q    <= cout_hold;
    end
  end

  assign carry_out_o = cout_q;

  // R6: the reported word carry does not move during the output window
  a_r6_cout_steady: assert property (@(posedge clk) disable iff (rst)
    (sum_valid_o && $past(sum_valid_o)) |-> $stable(carry_out_o));

  // R4: the lowest lane is always seeded with zero
  a_r4_base_seed: assert property (@(posedge clk) disable iff (rst)
    seed_en |=> (g_lane[0].u_lane.run_c == 1'b0));

endmodule

// File: tb/sim_segadd_top.sv
module sim_segadd_top;

  localparam int LANES = 4;
  localparam int SEG   = 8;
  localparam int W     = LANES * SEG;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [LANES-1:0] a_i = '0;
  logic [LANES-1:0] b_i = '0;
  logic [LANES-1:0] sum_o;
  logic             sum_valid_o, done_o, carry_out_o;

  segadd_top #(.LANES(LANES), .SEG_LEN(SEG)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .sum_o(sum_o), .sum_valid_o(sum_valid_o), .done_o(done_o),
    .carry_out_o(carry_out_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  logic [LANES-1:0] q_bits[$];
  int               q_rise[$];
  logic             q_cout[$];

  logic prev_valid = 1'b0;
  int   beats = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (sum_valid_o) begin
        if (!prev_valid) begin
          beats = 0;
          if (q_rise.size() == 0) check(1'b0, "R7 unexpected run", 64'(cyc), 0);
          else begin
            int r;
            r = q_rise.pop_front();
            check(cyc == r, "R3 first valid cycle", 64'(cyc), 64'(r));
          end
        end
        beats++;
        if (q_bits.size() == 0) check(1'b0, "R7 unexpected sum beat", 64'(sum_o), 0);
        else begin
          logic [LANES-1:0] e;
          e = q_bits.pop_front();
          check(sum_o == e, "R2 sum beat", 64'(sum_o), 64'(e));
        end
      end
      if (done_o) begin
        done_cnt++;
        check(prev_valid && !sum_valid_o, "R5 done placement", 64'({prev_valid, sum_valid_o}), 64'(2'b10));
        check(beats == SEG, "R3 beat count", 64'(beats), 64'(SEG));
        if (q_cout.size() == 0) check(1'b0, "R5 extra done", 1, 0);
        else begin
          logic ec;
          ec = q_cout.pop_front();
          check(carry_out_o == ec, "R6 carry out", 64'(carry_out_o), 64'(ec));
        end
      end
      prev_valid <= sum_valid_o;
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy);
    logic [W:0] s;
    int sc;
    int target;
    s = {1'b0, a} + {1'b0, b};
    target = done_cnt + 1;
    @(negedge clk);
    sc = cyc;
    q_rise.push_back(sc + SEG + 3);
    for (int k = 0; k < SEG; k++) begin
      logic [LANES-1:0] e;
      for (int l = 0; l < LANES; l++) e[l] = s[l*SEG + k];
      q_bits.push_back(e);
    end
    q_cout.push_back(s[W]);
    for (int k = 0; k < SEG; k++) begin
      if (k > 0) @(negedge clk);
      start_i = (k == 0) || noisy;
      for (int l = 0; l < LANES; l++) begin
        a_i[l] = a[l*SEG + k];
        b_i[l] = b[l*SEG + k];
      end
    end
    @(negedge clk);
    if (noisy) begin
      // R7: busy-time start and operand activity must be ignored
      start_i = 1'b1;
      a_i = '1;
      b_i = '1;
      repeat (SEG - 1) @(negedge clk);
    end
    start_i = 1'b0;
    a_i = '0;
    b_i = '0;
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic rand_word(output logic [W-1:0] w);
    for (int i = 0; i < W; i += 32) begin
      rs = xs(rs);
      for (int j = 0; j < 32; j++) if (i + j < W) w[i+j] = rs[j];
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(sum_valid_o == 1'b0, "R9 sum_valid after reset", 64'(sum_valid_o), 0);
    check(done_o == 1'b0, "R9 done after reset", 64'(done_o), 0);
    check(carry_out_o == 1'b0, "R9 carry_out after reset", 64'(carry_out_o), 0);

    run_op('0, '0, 1'b0);                        // R2 all kill
    run_op({W{1'b1}}, W'(1), 1'b0);              // R8 full propagate chain, R6 carry out 1
    run_op(W'(32'h0000_00FF), '0, 1'b0);         // R4 lowest slice all propagate, no carry-in
    run_op(W'(32'h00FF_FF80), W'(32'h0000_0080), 1'b0); // R8 carry over two propagate lanes
    run_op({W{1'b1}}, {W{1'b1}}, 1'b0);          // R1 all generate
    run_op(W'(32'hA5A5_5A5A), W'(32'h5A5A_A5A5), 1'b1); // R7 noisy start during busy phases
    for (int t = 0; t < 6; t++) begin
      logic [W-1:0] ra, rb;
      rand_word(ra);
      rand_word(rb);
      run_op(ra, rb, t[0]);
    end
    repeat (3 * SEG) @(negedge clk);
    check(q_bits.size() == 0 && q_cout.size() == 0, "R5 pending expectations",
          64'(q_bits.size() + q_cout.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule